// File: doc/BRIEF.md
# Data-Side Bus Router with Peripheral Registers

This block sits between the load/store port of a processor core and two kinds of target: a word-wide RAM with per-byte write enables, and a small window of memory-mapped peripheral registers. A request (address, size, write flag, store data, and a flag that selects zero or sign extension) is decoded by the top nibble of its address. The block then writes the RAM or the peripheral registers, or starts a read. Every read answers exactly one clock after it is accepted, whichever target it hits. The read response is steered by a registered copy of the target select, so RAM reads and register reads arrive on the same cycle.

The register window has three locations. One is a transmit-data register that hands a byte to a serial transmitter through a start pulse and a data bus. One is a status register that reports the transmitter's ready flag. One is a write-only register that drives the LED outputs. The block offers a write to the transmitter only when the transmitter reports ready, so a store that arrives while it is busy is dropped and never overruns it. Loads of bytes and halfwords are extracted from the returned word and extended according to the request.

Top module: `dbus_router`

## Requirements
- R1: A read request (`req_valid`=1, `req_write`=0) gives `rsp_valid`=1 on the clock after acceptance, for one cycle only, and the read data appears in that same cycle. In every other cycle `rsp_valid`=0 and `rsp_rdata`=0. Writes give no response.
- R2: Address bits [31:28] pick the target: 0x0 selects RAM, 0x1 and 0x2 select the register window, and any other value selects nothing. Within the RAM region the word index is the address bits [RAM_AW+1:2], so higher address bits alias.
- R3: `req_size` encodes 0 as byte, 1 as halfword and 2 or 3 as word. A byte store writes only lane `addr[1:0]` with `wdata[7:0]`. A halfword store writes lanes 0–1 (`addr[1]`=0) or lanes 2–3 (`addr[1]`=1) with `wdata[15:0]`. A word store writes all four lanes. Lanes that are not written keep their contents.
- R4: A byte load returns lane `addr[1:0]`, and a halfword load returns the half chosen by `addr[1]`, in the low bits. Both are sign-extended when `req_unsigned`=0 and zero-extended when it is 1. A word load returns the whole word.
- R5: A store to 0x1000_0000 while `uart_ready`=1 gives a one-cycle `uart_start` pulse on the following clock, with `uart_data` equal to the stored bits [7:0].
- R6: A store to 0x1000_0000 while `uart_ready`=0 is dropped: no `uart_start` pulse follows.
- R7: A word read of 0x1000_0004 returns `uart_ready`, sampled in the response cycle, in bit 0, with all other bits zero.
- R8: A store to 0x2000_0000 loads `led` from bits [LED_W-1:0] on the following clock. `led` changes at no other time and resets to 0.
- R9: Reads of unmapped addresses and of the write-only locations (0x1000_0000, 0x2000_0000) return 0. Stores to unmapped addresses change neither RAM nor any output.
- R10: A RAM read followed by a register read on the very next cycle gives two responses on consecutive cycles, each carrying its own target's data.
- R11: While `rst_n`=0, `rsp_valid`, `rsp_rdata`, `uart_start` and `led` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_unsigned | input | 1 | Zero-extend sub-word loads |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |
| uart_ready | input | 1 | Transmitter can accept a byte |
| uart_start | output | 1 | One-cycle transmit start pulse |
| uart_data | output | 8 | Byte to transmit |
| led | output | LED_W | LED output register |

## Verification
On every cycle the bound checker enforces the one-cycle read response and the zero idle data. It also checks the status-register contents against the live ready flag, the zero data from unmapped regions, and that a start pulse appears only after an accepted store while ready, with the right byte. It further checks that the LED register holds between its own writes. Lane steering for sub-word stores, sign and zero extension, address aliasing, unmapped stores leaving RAM intact, and a RAM read followed at once by a register read can only be shown by the bench. The bench runs scenarios against its own memory model to cover these.

// File: rtl/dbus_pkg.sv
package dbus_pkg;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_RAM  = 2'd1,
      TGT_MMIO = 2'd2
   } dbus_tgt_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WIDE = 2'd3
   } dbus_size_e;

   localparam logic [3:0]  REGION_RAM  = 4'h0;
   localparam logic [3:0]  REGION_SER  = 4'h1;
   localparam logic [3:0]  REGION_LAMP = 4'h2;

   localparam logic [31:0] ADDR_TX_DATA = 32'h1000_0000;
   localparam logic [31:0] ADDR_TX_STAT = 32'h1000_0004;
   localparam logic [31:0] ADDR_LAMP    = 32'h2000_0000;

endpackage

// File: rtl/dbus_decode.sv
module dbus_decode
   import dbus_pkg::*;
(
   input  logic [31:0] addr,
   output dbus_tgt_e   tgt
);

   always_comb begin
      unique case (addr[31:28])
         REGION_RAM:              tgt = TGT_RAM;
         REGION_SER, REGION_LAMP: tgt = TGT_MMIO;
         default:                 tgt = TGT_NONE;
      endcase
   end

endmodule

// File: rtl/dbus_lane_steer.sv
module dbus_lane_steer #(
   parameter int DATA_W = 32
) (
   input  logic [1:0]          size,
   input  logic [1:0]          offset,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W/8-1:0] lane_en,
   output logic [DATA_W-1:0]   lane_data
);

   localparam int LANES = DATA_W / 8;

   logic is_byte, is_half;
   assign is_byte = (size == 2'd0);
   assign is_half = (size == 2'd1);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam logic [1:0] LANE_ID = 2'(i);
      assign lane_en[i] = is_byte ? (offset == LANE_ID)
                        : is_half ? (offset[1] == LANE_ID[1])
                        : 1'b1;
      assign lane_data[8*i +: 8] = is_byte ? wdata[7:0]
                                 : is_half ? wdata[8*(i%2) +: 8]
                                 : wdata[8*i +: 8];
   end

endmodule

// File: rtl/dbus_ram.sv
module dbus_ram #(
   parameter int DATA_W = 32,
   parameter int WORDS  = 1024,
   localparam int AW    = $clog2(WORDS),
   localparam int LANES = DATA_W / 8
) (
   input  logic              clk,
   input  logic              en,
   input  logic              we,
   input  logic [LANES-1:0]  lane_en,
   input  logic [AW-1:0]     idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (en && we) begin
         for (int l = 0; l < LANES; l++) begin
            if (lane_en[l]) mem[idx][8*l +: 8] <= wdata[8*l +: 8];
         end
      end
      if (en && !we) rdata <= mem[idx];
   end

endmodule

// File: rtl/dbus_mmio.sv
module dbus_mmio
   import dbus_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LED_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic              write,
   input  logic [31:0]       addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              uart_ready,
   output logic              uart_start,
   output logic [7:0]        uart_data,
   output logic [LED_W-1:0]  led,
   output logic [DATA_W-1:0] rdata
);

   logic stat_rd_q;
   logic tx_wr, lamp_wr;

   assign tx_wr   = hit && write && (addr == ADDR_TX_DATA);
   assign lamp_wr = hit && write && (addr == ADDR_LAMP);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_rd_q  <= 1'b0;
         uart_start <= 1'b0;
         uart_data  <= '0;
         led        <= '0;
      end else begin
         stat_rd_q  <= hit && !write && (addr == ADDR_TX_STAT);
         uart_start <= tx_wr && uart_ready;
         if (tx_wr && uart_ready) uart_data <= wdata[7:0];
         if (lamp_wr) led <= wdata[LED_W-1:0];
      end
   end

   assign rdata = stat_rd_q ? {{(DATA_W-1){1'b0}}, uart_ready} : '0;

endmodule

// File: rtl/dbus_router.sv
module dbus_router
   import dbus_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int RAM_WORDS = 1024,
   parameter int LED_W     = 4,
   parameter bit RAW_LOADS = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic              req_unsigned,
   input  logic [31:0]       req_addr,
   input  logic [31:0]       req_wdata,
   output logic              rsp_valid,
   output logic [31:0]       rsp_rdata,
   input  logic              uart_ready,
   output logic              uart_start,
   output logic [7:0]        uart_data,
   output logic [LED_W-1:0]  led
);

   localparam int RAM_AW = $clog2(RAM_WORDS);
   localparam int LANES  = DATA_W / 8;

   if (DATA_W != 32) begin : g_bad_width
      $error("dbus_router: DATA_W must be 32");
   end
   if ((RAM_WORDS < 4) || ((RAM_WORDS & (RAM_WORDS - 1)) != 0) || (RAM_AW + 2 > 28)) begin : g_bad_depth
      $error("dbus_router: RAM_WORDS must be a power of two within the RAM region");
   end
   if ((LED_W < 1) || (LED_W > 8)) begin : g_bad_led
      $error("dbus_router: LED_W must be 1..8");
   end

   dbus_tgt_e tgt, sel_q;
   logic [LANES-1:0]  lane_en;
   logic [DATA_W-1:0] lane_data, ram_rdata, mmio_rdata, raw, shaped;
   logic              rvalid_q, uns_q;
   logic [1:0]        off_q, size_q;

   dbus_decode u_decode (
      .addr (req_addr),
      .tgt  (tgt)
   );

   dbus_lane_steer #(.DATA_W(DATA_W)) u_steer (
      .size      (req_size),
      .offset    (req_addr[1:0]),
      .wdata     (req_wdata),
      .lane_en   (lane_en),
      .lane_data (lane_data)
   );

   dbus_ram #(.DATA_W(DATA_W), .WORDS(RAM_WORDS)) u_ram (
      .clk     (clk),
      .en      (req_valid && (tgt == TGT_RAM)),
      .we      (req_write),
      .lane_en (lane_en),
      .idx     (req_addr[RAM_AW+1:2]),
      .wdata   (lane_data),
      .rdata   (ram_rdata)
   );

   dbus_mmio #(.DATA_W(DATA_W), .LED_W(LED_W)) u_mmio (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit        (req_valid && (tgt == TGT_MMIO)),
      .write      (req_write),
      .addr       (req_addr),
      .wdata      (lane_data),
      .uart_ready (uart_ready),
      .uart_start (uart_start),
      .uart_data  (uart_data),
      .led        (led),
      .rdata      (mmio_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         sel_q    <= TGT_NONE;
         off_q    <= '0;
         size_q   <= '0;
         uns_q    <= 1'b0;
      end else begin
         rvalid_q <= req_valid && !req_write;
         if (req_valid && !req_write) begin
            sel_q  <= tgt;
            off_q  <= req_addr[1:0];
            size_q <= req_size;
            uns_q  <= req_unsigned;
         end
      end
   end

   always_comb begin
      unique case (sel_q)
         TGT_RAM:  raw = ram_rdata;
         TGT_MMIO: raw = mmio_rdata;
         default:  raw = '0;
      endcase
   end

   if (RAW_LOADS) begin : g_raw
      assign shaped = raw;
   end else begin : g_extract
      logic [7:0]  b_sel;
      logic [15:0] h_sel;
      assign b_sel = raw[8*off_q +: 8];
      assign h_sel = off_q[1] ? raw[31:16] : raw[15:0];
      always_comb begin
         unique case (size_q)
            2'd0:    shaped = {{24{~uns_q & b_sel[7]}}, b_sel};
            2'd1:    shaped = {{16{~uns_q & h_sel[15]}}, h_sel};
            default: shaped = raw;
         endcase
      end
   end

   assign rsp_valid = rvalid_q;
   assign rsp_rdata = rvalid_q ? shaped : '0;

endmodule

// File: rtl/dbus_router_chk.sv
module dbus_router_chk
   import dbus_pkg::*;
#(
   parameter int LED_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_write,
   input logic [1:0]       req_size,
   input logic [31:0]      req_addr,
   input logic [31:0]      req_wdata,
   input logic             rsp_valid,
   input logic [31:0]      rsp_rdata,
   input logic             uart_ready,
   input logic             uart_start,
   input logic [7:0]       uart_data,
   input logic [LED_W-1:0] led
);

   AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rsp_valid); // R1
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write) |=> !rsp_valid); // R1
   AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (rsp_rdata == 32'h0)); // R1
   AST_START_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      uart_start |-> $past(req_valid && req_write && (req_addr == ADDR_TX_DATA) && uart_ready)); // R6
   AST_START_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      uart_start |-> (uart_data == $past(req_wdata[7:0]))); // R5
   AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past((req_addr == ADDR_TX_STAT) && (req_size == 2'd2)))
      |-> (rsp_rdata == {31'h0, uart_ready})); // R7
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && $past(req_addr[31:28] > REGION_LAMP)) |-> (rsp_rdata == 32'h0)); // R9
   AST_LED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(req_valid && req_write && (req_addr == ADDR_LAMP)) |-> $stable(led)); // R8

endmodule

bind dbus_router dbus_router_chk #(.LED_W(LED_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .req_size   (req_size),
   .req_addr   (req_addr),
   .req_wdata  (req_wdata),
   .rsp_valid  (rsp_valid),
   .rsp_rdata  (rsp_rdata),
   .uart_ready (uart_ready),
   .uart_start (uart_start),
   .uart_data  (uart_data),
   .led        (led)
);

// File: tb/tb_dbus_router.sv
module tb_dbus_router;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_unsigned = 1'b0;
   logic [1:0]  req_size = 2'd2;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        uart_ready = 1'b1;
   logic        uart_start;
   logic [7:0]  uart_data;
   logic [3:0]  led;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   logic [31:0] model [1024];
   logic        seen_start;
   logic [7:0]  seen_data;

   always #4 clk = ~clk;

   dbus_router dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_size(req_size), .req_unsigned(req_unsigned), .req_addr(req_addr),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .uart_ready(uart_ready), .uart_start(uart_start), .uart_data(uart_data),
      .led(led)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] store_merge(input logic [31:0] old, input logic [1:0] off,
                                               input logic [1:0] size, input logic [31:0] d);
      logic [31:0] r = old;
      if (size == 2'd0)      r[8*off +: 8] = d[7:0];
      else if (size == 2'd1) r[16*off[1] +: 16] = d[15:0];
      else                   r = d;
      return r;
   endfunction

   function automatic logic [31:0] load_shape(input logic [31:0] w, input logic [1:0] off,
                                              input logic [1:0] size, input logic uns);
      logic [7:0]  b = w[8*off +: 8];
      logic [15:0] h = w[16*off[1] +: 16];
      if (size == 2'd0)      return uns ? {24'h0, b} : {{24{b[7]}}, b};
      else if (size == 2'd1) return uns ? {16'h0, h} : {{16{h[15]}}, h};
      return w;
   endfunction

   task automatic bus_write(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      seen_start = uart_start;
      seen_data  = uart_data;
      if (a[31:28] == 4'h0) model[a[11:2]] = store_merge(model[a[11:2]], a[1:0], sz, d);
   endtask

   task automatic bus_read(input logic [31:0] a, input logic [1:0] sz, input logic uns,
                           input logic [31:0] exp, input string req);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz; req_unsigned = uns;
      @(negedge clk);
      req_valid = 1'b0;
      check({req, " rsp_valid"}, {31'h0, rsp_valid}, 32'h1);
      check(req, rsp_rdata, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd5150));
      repeat (3) @(negedge clk);
      // R11: reset state
      check("R11 rsp_valid", {31'h0, rsp_valid}, 32'h0);
      check("R11 rsp_rdata", rsp_rdata, 32'h0);
      check("R11 uart_start", {31'h0, uart_start}, 32'h0);
      check("R11 led", {28'h0, led}, 32'h0);
      rst_n = 1'b1;

      for (int i = 0; i < 64; i++) bus_write(32'(i * 4), 2'd2, 32'h0);

      // R1: idle after a write
      check("R1 no rsp after write", {31'h0, rsp_valid}, 32'h0);

      // R3 / R4 directed lanes and extension
      bus_write(32'h0000_0004, 2'd2, 32'h80FF_7F01);
      bus_read(32'h0000_0005, 2'd0, 1'b0, 32'h0000_007F, "R4 byte1 signed");
      bus_read(32'h0000_0006, 2'd0, 1'b0, 32'hFFFF_FFFF, "R4 byte2 signed");
      bus_read(32'h0000_0007, 2'd0, 1'b1, 32'h0000_0080, "R4 byte3 unsigned");
      bus_read(32'h0000_0006, 2'd1, 1'b0, 32'hFFFF_80FF, "R4 half hi signed");
      bus_read(32'h0000_0004, 2'd1, 1'b1, 32'h0000_7F01, "R4 half lo unsigned");
      bus_write(32'h0000_0006, 2'd0, 32'hAAAA_AA5C);
      bus_read(32'h0000_0004, 2'd2, 1'b0, 32'h805C_7F01, "R3 byte store lane2");
      bus_write(32'h0000_0006, 2'd1, 32'h1234_BEEF);
      bus_read(32'h0000_0004, 2'd2, 1'b0, 32'hBEEF_7F01, "R3 half store upper");

      // R2: aliasing above RAM depth
      bus_write(32'h0000_1014, 2'd2, 32'hCAFE_0005);
      bus_read(32'h0000_0014, 2'd2, 1'b0, 32'hCAFE_0005, "R2 alias word5");

      // R5 / R6 transmitter
      uart_ready = 1'b0;
      bus_write(32'h1000_0000, 2'd2, 32'h0000_0141);
      check("R6 no start while busy", {31'h0, seen_start}, 32'h0);
      uart_ready = 1'b1;
      bus_write(32'h1000_0000, 2'd2, 32'h0000_01C3);
      check("R5 start pulse", {31'h0, seen_start}, 32'h1);
      check("R5 start data", {24'h0, seen_data}, 32'h0000_00C3);
      @(negedge clk);
      check("R5 pulse one cycle", {31'h0, uart_start}, 32'h0);

      // R7 status polling
      bus_read(32'h1000_0004, 2'd2, 1'b0, 32'h1, "R7 status ready");
      uart_ready = 1'b0;
      bus_read(32'h1000_0004, 2'd2, 1'b0, 32'h0, "R7 status busy");
      uart_ready = 1'b1;

      // R8 LED
      bus_write(32'h2000_0000, 2'd2, 32'h0000_00A5);
      check("R8 led load", {28'h0, led}, 32'h5);
      bus_write(32'h0000_0008, 2'd2, 32'h0000_000F);
      check("R8 led holds", {28'h0, led}, 32'h5);

      // R9 unmapped and write-only
      bus_write(32'h3000_0000, 2'd2, 32'hDEAD_BEEF);
      check("R9 unmapped store led", {28'h0, led}, 32'h5);
      bus_read(32'h0000_0000, 2'd2, 1'b0, 32'h0, "R9 unmapped store ram intact");
      bus_read(32'h3000_0000, 2'd2, 1'b0, 32'h0, "R9 unmapped read");
      bus_read(32'h1000_0008, 2'd2, 1'b0, 32'h0, "R9 window hole read");
      bus_read(32'h1000_0000, 2'd2, 1'b0, 32'h0, "R9 tx data read");
      bus_read(32'h2000_0000, 2'd2, 1'b0, 32'h0, "R9 led read");

      // R10 back-to-back RAM then status
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h0000_0014; req_size = 2'd2;
      @(negedge clk);
      check("R10 first rsp", rsp_rdata, 32'hCAFE_0005);
      req_addr = 32'h1000_0004;
      @(negedge clk);
      req_valid = 1'b0;
      check("R10 second rsp valid", {31'h0, rsp_valid}, 32'h1);
      check("R10 second rsp", rsp_rdata, 32'h1);
      @(negedge clk);
      check("R1 rsp drops", {31'h0, rsp_valid}, 32'h0);
      check("R1 idle data zero", rsp_rdata, 32'h0);

      // random RAM traffic (R3, R4)
      for (int i = 0; i < 600; i++) begin
         logic [31:0] a;
         logic [1:0]  sz;
         logic        u;
         a  = {20'h0, 4'($urandom_range(0, 15)), 6'($urandom_range(0, 63)), 2'($urandom_range(0, 3))};
         a[11:8] = 4'h0;
         sz = 2'($urandom_range(0, 3));
         u  = 1'($urandom_range(0, 1));
         if ($urandom_range(0, 1) == 0) begin
            bus_write(a, sz, $urandom);
         end else begin
            bus_read(a, sz, u, load_shape(model[a[11:2]], a[1:0], sz, u), "R3 R4 random load");
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule